// File: doc/BRIEF.md
# Rectangle Fill and Copy Blitter

This block is a small 2D drawing engine that sits next to a video memory and rewrites rectangular regions of it. It performs one of two operations. A fill combines a constant colour with every pixel of a destination rectangle. A copy combines each pixel of a source rectangle with the matching destination pixel. In both cases a 4-bit raster operation code chooses the logical function applied to the two operands before the result is written back.

Software sets up the job through a small register port: a base offset and a pitch for each surface, the rectangle corners, the size, the colour and the raster code. A write to the command register starts the job. While the engine works it reports busy and ignores every further register write. When a copy has overlapping source and destination, the engine picks its row and column order by itself, so it never reads a pixel that it has already overwritten.

The memory port uses byte addresses, and each access moves exactly one pixel of `PIX_W` bits. Read data comes back one cycle after the read request.

Top module: `rect_blitter`

## Requirements
- R1: During and after reset, `busy`, `mem_rd_en` and `mem_wr_en` are low.
- R2: Register addresses: 0 dst base, 1 dst pitch, 2 src base, 3 src pitch, 4 dst x, 5 dst y, 6 src x, 7 src y, 8 width, 9 height, 10 colour, 11 raster code (bits 3:0), 15 command. On a command write, wdata bit 0 picks the operation: 1 is copy, 0 is fill. `busy` goes high in the cycle after the command write.
- R3: A pixel at (x,y) of a surface sits at byte address base + y*pitch + x*(PIX_W/8), taken modulo 2^ADDR_W.
- R4: A fill sets each destination pixel to rop(colour, old destination).
- R5: Raster function: result bit b = code[2*s_b + d_b], where s is the source or colour operand and d is the old destination. So 0xC passes the source, 0x6 is XOR, 0xA keeps the destination, 0x0 gives all zeros and 0xF gives all ones.
- R6: A copy leaves each destination pixel equal to rop(original source pixel, old destination pixel), even when the two rectangles overlap.
- R7: A copy walks rows bottom-to-top when dst y > src y. When the two y values are equal and dst x > src x, it walks columns right-to-left. In every other case it walks top-to-bottom and left-to-right.
- R8: Each non-empty job makes exactly width*height memory writes. `busy` stays high for exactly 2 cycles per pixel for a fill and 3 cycles per pixel for a copy.
- R9: Register writes, including command writes, have no effect while `busy` is high.
- R10: A command with width 0 or height 0 causes no memory access, and `busy` stays low.
- R11: No memory word outside the destination rectangle is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | REG_W | Register write data |
| busy | output | 1 | A job is in progress |
| mem_rd_en | output | 1 | Memory read request |
| mem_wr_en | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | PIX_W | Pixel write data |
| mem_rdata | input | PIX_W | Read data, valid one cycle after the request |

## Verification
The bench builds the engine with ADDR_W=12, COORD_W=5 and PIX_W=16. This gives two-byte pixels, so the address scaling is exercised, and a 2048-word memory that the bench compares in full against its own model after every job. These small sizes allow a sweep of all sixteen raster codes for both operations and a sweep of rectangle sizes. They also allow overlapping copies in each of the four directions, a copy between surfaces with different pitches, empty rectangles, and register writes injected while a job runs.

// File: rtl/blit_pkg.sv
package blit_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RD_SRC = 2'd1,
    ST_RD_DST = 2'd2,
    ST_WR     = 2'd3
  } blit_state_e;

  localparam logic [3:0] RA_DST_BASE  = 4'd0;
  localparam logic [3:0] RA_DST_PITCH = 4'd1;
  localparam logic [3:0] RA_SRC_BASE  = 4'd2;
  localparam logic [3:0] RA_SRC_PITCH = 4'd3;
  localparam logic [3:0] RA_DST_X     = 4'd4;
  localparam logic [3:0] RA_DST_Y     = 4'd5;
  localparam logic [3:0] RA_SRC_X     = 4'd6;
  localparam logic [3:0] RA_SRC_Y     = 4'd7;
  localparam logic [3:0] RA_WIDTH     = 4'd8;
  localparam logic [3:0] RA_HEIGHT    = 4'd9;
  localparam logic [3:0] RA_COLOUR    = 4'd10;
  localparam logic [3:0] RA_ROP       = 4'd11;
  localparam logic [3:0] RA_CMD       = 4'd15;

endpackage

// File: rtl/blit_regs.sv
module blit_regs
  import blit_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int COORD_W = 8,
  parameter int PIX_W   = 16,
  parameter int REG_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [3:0]         addr,
  input  logic [REG_W-1:0]   wdata,
  input  logic               busy,
  output logic [ADDR_W-1:0]  dst_base,
  output logic [ADDR_W-1:0]  dst_pitch,
  output logic [ADDR_W-1:0]  src_base,
  output logic [ADDR_W-1:0]  src_pitch,
  output logic [COORD_W-1:0] dst_x,
  output logic [COORD_W-1:0] dst_y,
  output logic [COORD_W-1:0] src_x,
  output logic [COORD_W-1:0] src_y,
  output logic [COORD_W-1:0] width,
  output logic [COORD_W-1:0] height,
  output logic [PIX_W-1:0]   colour,
  output logic [3:0]         rop,
  output logic               launch,
  output logic               launch_copy
);

  logic wr_ok;
  assign wr_ok       = wr_en && !busy;
  assign launch      = wr_ok && (addr == RA_CMD);
  assign launch_copy = wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_base  <= '0;
      dst_pitch <= '0;
      src_base  <= '0;
      src_pitch <= '0;
      dst_x     <= '0;
      dst_y     <= '0;
      src_x     <= '0;
      src_y     <= '0;
      width     <= '0;
      height    <= '0;
      colour    <= '0;
      rop       <= '0;
    end else if (wr_ok) begin
      case (addr)
        RA_DST_BASE:  dst_base  <= wdata[ADDR_W-1:0];
        RA_DST_PITCH: dst_pitch <= wdata[ADDR_W-1:0];
        RA_SRC_BASE:  src_base  <= wdata[ADDR_W-1:0];
        RA_SRC_PITCH: src_pitch <= wdata[ADDR_W-1:0];
        RA_DST_X:     dst_x     <= wdata[COORD_W-1:0];
        RA_DST_Y:     dst_y     <= wdata[COORD_W-1:0];
        RA_SRC_X:     src_x     <= wdata[COORD_W-1:0];
        RA_SRC_Y:     src_y     <= wdata[COORD_W-1:0];
        RA_WIDTH:     width     <= wdata[COORD_W-1:0];
        RA_HEIGHT:    height    <= wdata[COORD_W-1:0];
        RA_COLOUR:    colour    <= wdata[PIX_W-1:0];
        RA_ROP:       rop       <= wdata[3:0];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/blit_walker.sv
module blit_walker #(
  parameter int COORD_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               step,
  input  logic [COORD_W-1:0] width,
  input  logic [COORD_W-1:0] height,
  output logic [COORD_W-1:0] col,
  output logic [COORD_W-1:0] row,
  output logic               last
);

  logic [COORD_W-1:0] col_d, row_d;
  logic [COORD_W-1:0] w_m1, h_m1;
  logic               row_end;

  assign w_m1    = width - 1'b1;
  assign h_m1    = height - 1'b1;
  assign row_end = (col == w_m1);
  assign last    = row_end && (row == h_m1);

  always_comb begin
    col_d = col;
    row_d = row;
    if (clear) begin
      col_d = '0;
      row_d = '0;
    end else if (step) begin
      if (row_end) begin
        col_d = '0;
        row_d = row + 1'b1;
      end else begin
        col_d = col + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col <= '0;
      row <= '0;
    end else begin
      col <= col_d;
      row <= row_d;
    end
  end

endmodule

// File: rtl/blit_addr.sv
module blit_addr #(
  parameter int ADDR_W  = 16,
  parameter int COORD_W = 8,
  parameter int PIX_W   = 16
) (
  input  logic               copy,
  input  logic [COORD_W-1:0] col,
  input  logic [COORD_W-1:0] row,
  input  logic [COORD_W-1:0] width,
  input  logic [COORD_W-1:0] height,
  input  logic [ADDR_W-1:0]  src_base,
  input  logic [ADDR_W-1:0]  src_pitch,
  input  logic [COORD_W-1:0] src_x,
  input  logic [COORD_W-1:0] src_y,
  input  logic [ADDR_W-1:0]  dst_base,
  input  logic [ADDR_W-1:0]  dst_pitch,
  input  logic [COORD_W-1:0] dst_x,
  input  logic [COORD_W-1:0] dst_y,
  output logic [ADDR_W-1:0]  src_addr,
  output logic [ADDR_W-1:0]  dst_addr
);

  localparam int BPP = PIX_W / 8;

  logic               rev_x, rev_y;
  logic [COORD_W-1:0] x_off, y_off;
  logic [ADDR_W-1:0]  sx, sy, dx, dy, x_scale_s, x_scale_d;

  // overlap-safe walk order
  assign rev_y = copy && (dst_y > src_y);
  assign rev_x = copy && (dst_y == src_y) && (dst_x > src_x);

  assign x_off = rev_x ? (width - 1'b1 - col) : col;
  assign y_off = rev_y ? (height - 1'b1 - row) : row;

  assign sx = ADDR_W'(src_x) + ADDR_W'(x_off);
  assign sy = ADDR_W'(src_y) + ADDR_W'(y_off);
  assign dx = ADDR_W'(dst_x) + ADDR_W'(x_off);
  assign dy = ADDR_W'(dst_y) + ADDR_W'(y_off);

  generate
    if (BPP == 1) begin : g_byte_pix
      assign x_scale_s = sx;
      assign x_scale_d = dx;
    end else begin : g_multi_byte_pix
      assign x_scale_s = sx * ADDR_W'(BPP);
      assign x_scale_d = dx * ADDR_W'(BPP);
    end
  endgenerate

  assign src_addr = src_base + sy * src_pitch + x_scale_s;
  assign dst_addr = dst_base + dy * dst_pitch + x_scale_d;

endmodule

// File: rtl/rect_blitter.sv
module rect_blitter
  import blit_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int COORD_W = 8,
  parameter int PIX_W   = 16,
  parameter int REG_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [3:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic              busy,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [PIX_W-1:0]  mem_wdata,
  input  logic [PIX_W-1:0]  mem_rdata
);

  logic [ADDR_W-1:0]  dst_base, dst_pitch, src_base, src_pitch;
  logic [COORD_W-1:0] dst_x, dst_y, src_x, src_y, width, height;
  logic [PIX_W-1:0]   colour;
  logic [3:0]         rop;
  logic               launch, launch_copy, start;

  logic [COORD_W-1:0] col, row;
  logic               last, clear, step;
  logic [ADDR_W-1:0]  src_addr, dst_addr;

  blit_state_e        state_q, state_d;
  logic               copy_q;
  logic [PIX_W-1:0]   src_q;
  logic               src_en;
  logic [PIX_W-1:0]   s_opnd;

  blit_regs #(
    .ADDR_W(ADDR_W), .COORD_W(COORD_W), .PIX_W(PIX_W), .REG_W(REG_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata), .busy(busy),
    .dst_base(dst_base), .dst_pitch(dst_pitch),
    .src_base(src_base), .src_pitch(src_pitch),
    .dst_x(dst_x), .dst_y(dst_y), .src_x(src_x), .src_y(src_y),
    .width(width), .height(height), .colour(colour), .rop(rop),
    .launch(launch), .launch_copy(launch_copy)
  );

  blit_walker #(.COORD_W(COORD_W)) u_walker (
    .clk(clk), .rst_n(rst_n), .clear(clear), .step(step),
    .width(width), .height(height), .col(col), .row(row), .last(last)
  );

  blit_addr #(.ADDR_W(ADDR_W), .COORD_W(COORD_W), .PIX_W(PIX_W)) u_addr (
    .copy(copy_q), .col(col), .row(row), .width(width), .height(height),
    .src_base(src_base), .src_pitch(src_pitch), .src_x(src_x), .src_y(src_y),
    .dst_base(dst_base), .dst_pitch(dst_pitch), .dst_x(dst_x), .dst_y(dst_y),
    .src_addr(src_addr), .dst_addr(dst_addr)
  );

  assign start = launch && (width != '0) && (height != '0);
  assign busy  = (state_q != ST_IDLE);

  always_comb begin
    state_d   = state_q;
    mem_rd_en = 1'b0;
    mem_wr_en = 1'b0;
    mem_addr  = dst_addr;
    clear     = 1'b0;
    step      = 1'b0;
    src_en    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          clear   = 1'b1;
          state_d = launch_copy ? ST_RD_SRC : ST_RD_DST;
        end
      end
      ST_RD_SRC: begin
        mem_rd_en = 1'b1;
        mem_addr  = src_addr;
        state_d   = ST_RD_DST;
      end
      ST_RD_DST: begin
        mem_rd_en = 1'b1;
        src_en    = copy_q;
        state_d   = ST_WR;
      end
      ST_WR: begin
        mem_wr_en = 1'b1;
        step      = 1'b1;
        if (last) state_d = ST_IDLE;
        else      state_d = copy_q ? ST_RD_SRC : ST_RD_DST;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     copy_q <= 1'b0;
    else if (start) copy_q <= launch_copy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      src_q <= '0;
    else if (src_en) src_q <= mem_rdata;
  end

  assign s_opnd = copy_q ? src_q : colour;

  // raster function: bit b takes rop[{s_b, d_b}]
  genvar b;
  generate
    for (b = 0; b < PIX_W; b++) begin : g_rop_bit
      assign mem_wdata[b] = rop[{s_opnd[b], mem_rdata[b]}];
    end
  endgenerate

endmodule

// File: rtl/rect_blitter_checker.sv
module rect_blitter_checker #(
  parameter int COORD_W = 8,
  parameter int PIX_W   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               mem_rd_en,
  input logic               mem_wr_en,
  input logic               reg_wr_en,
  input logic [PIX_W-1:0]   colour,
  input logic [3:0]         rop,
  input logic [COORD_W-1:0] width,
  input logic [COORD_W-1:0] height
);

  always_comb begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!busy && !mem_rd_en && !mem_wr_en); // R1
    end
  end

  AST_WR_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> busy); // R10

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en)); // R8

  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> $past(mem_rd_en)); // R4

  AST_END_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(mem_wr_en)); // R8

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr_en) |=> ($stable(colour) && $stable(rop)
                             && $stable(width) && $stable(height))); // R9

endmodule

bind rect_blitter rect_blitter_checker #(.COORD_W(COORD_W), .PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_rd_en(mem_rd_en),
  .mem_wr_en(mem_wr_en), .reg_wr_en(reg_wr_en), .colour(colour),
  .rop(rop), .width(width), .height(height)
);

// File: tb/rect_blitter_bench.sv
module rect_blitter_bench;

  localparam int ADDR_W  = 12;
  localparam int COORD_W = 5;
  localparam int PIX_W   = 16;
  localparam int REG_W   = 32;
  localparam int WORDS   = 2048;

  logic              clk;
  logic              rst_n;
  logic              reg_wr_en;
  logic [3:0]        reg_addr;
  logic [REG_W-1:0]  reg_wdata;
  logic              busy;
  logic              mem_rd_en, mem_wr_en;
  logic [ADDR_W-1:0] mem_addr;
  logic [PIX_W-1:0]  mem_wdata, mem_rdata;

  logic              tb_we;
  int                tb_idx;
  logic [PIX_W-1:0]  tb_d;

  logic [PIX_W-1:0]  mem  [0:WORDS-1];
  logic [PIX_W-1:0]  refm [0:WORDS-1];
  logic [PIX_W-1:0]  tmp  [0:1023];

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [PIX_W-1:0] cur_col;

  rect_blitter #(.ADDR_W(ADDR_W), .COORD_W(COORD_W), .PIX_W(PIX_W), .REG_W(REG_W))
  u_rect_blitter (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .busy(busy), .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (tb_we) mem[tb_idx] <= tb_d;
    else if (mem_wr_en) mem[mem_addr[ADDR_W-1:1]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[ADDR_W-1:1]];
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [PIX_W-1:0] ropf(input logic [3:0] r,
                                            input logic [PIX_W-1:0] s,
                                            input logic [PIX_W-1:0] d);
    logic [PIX_W-1:0] o;
    for (int b = 0; b < PIX_W; b++) o[b] = r[{s[b], d[b]}];
    return o;
  endfunction

  task automatic wreg(input logic [3:0] a, input int d);
    reg_wr_en = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic compare_mem(input string req);
    int mism = 0;
    for (int i = 0; i < WORDS; i++) if (mem[i] !== refm[i]) mism++;
    check(mism == 0, req, mism, 0);
  endtask

  // copy: 1 = copy, 0 = fill; inject: write registers while busy
  task automatic run_op(input bit copy, input int sb, input int sp, input int db,
                        input int dp, input int sx, input int sy, input int dx,
                        input int dy, input int w, input int h, input int col,
                        input int rop, input bit skip_col, input bit inject,
                        input string tag);
    int cycles = 0;
    int writes = 0;
    int n = 0;
    wreg(4'd0, db); wreg(4'd1, dp); wreg(4'd2, sb); wreg(4'd3, sp);
    wreg(4'd4, dx); wreg(4'd5, dy); wreg(4'd6, sx); wreg(4'd7, sy);
    wreg(4'd8, w);  wreg(4'd9, h);  wreg(4'd11, rop);
    if (!skip_col) begin
      wreg(4'd10, col);
      cur_col = col[PIX_W-1:0];
    end
    // expected image: source snapshot first, then combine
    if (copy) begin
      for (int j = 0; j < h; j++)
        for (int i = 0; i < w; i++)
          tmp[j*w+i] = refm[((sb + (sy+j)*sp + (sx+i)*2) % 4096) / 2];
    end
    for (int j = 0; j < h; j++)
      for (int i = 0; i < w; i++) begin
        int di;
        di = ((db + (dy+j)*dp + (dx+i)*2) % 4096) / 2;
        refm[di] = ropf(rop[3:0], copy ? tmp[j*w+i] : cur_col, refm[di]);
      end
    wreg(4'd15, copy ? 1 : 0);
    if (w == 0 || h == 0) begin
      check(busy == 1'b0, {"R10 busy after empty command ", tag}, busy, 0);
    end else begin
      check(busy == 1'b1, {"R2 busy after command ", tag}, busy, 1);
    end
    while (busy && n < 20000) begin
      cycles++;
      if (mem_wr_en) writes++;
      if (inject && cycles == 2) begin
        reg_wr_en = 1'b1; reg_addr = 4'd10; reg_wdata = 32'h0000_1357;
      end else if (inject && cycles == 3) begin
        reg_addr = 4'd11; reg_wdata = 32'h3;
      end else if (inject && cycles == 4) begin
        reg_addr = 4'd15; reg_wdata = 32'h1;
      end else if (inject && cycles == 5) begin
        reg_wr_en = 1'b0;
      end
      n++;
      @(negedge clk);
    end
    reg_wr_en = 1'b0;
    repeat (2) begin
      if (mem_wr_en || mem_rd_en) writes += 1000;
      @(negedge clk);
    end
    check(cycles == w*h*(copy ? 3 : 2), {"R8 busy cycles ", tag}, cycles, w*h*(copy ? 3 : 2));
    check(writes == w*h, {"R8 write count ", tag}, writes, w*h);
    compare_mem({copy ? "R6 R7 R11 copy image " : "R4 R5 R11 fill image ", tag});
  endtask

  initial begin
    reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0;
    tb_we = 1'b0; tb_idx = 0; tb_d = '0; cur_col = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy && !mem_rd_en && !mem_wr_en, "R1 quiet in reset", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !mem_rd_en && !mem_wr_en, "R1 quiet after reset", busy, 0);
    for (int i = 0; i < WORDS; i++) begin
      tb_we = 1'b1; tb_idx = i; tb_d = PIX_W'((i * 40503 + 91) ^ (i >> 3));
      refm[i] = PIX_W'((i * 40503 + 91) ^ (i >> 3));
      @(negedge clk);
    end
    tb_we = 1'b0;
    @(negedge clk);

    // R5: every raster code, fill and copy
    for (int r = 0; r < 16; r++) begin
      run_op(1'b0, 0, 64, 0, 64, 0, 0, (r % 6) * 4, 20 + r / 6, 4, 1,
             16'hC3A5 ^ (r * 4369), r, 1'b0, 1'b0, $sformatf("R5 fill rop %0d", r));
      run_op(1'b1, 0, 64, 2048, 40, r, 2, (r % 4) * 4, 1 + r, 3, 2,
             0, r, 1'b0, 1'b0, $sformatf("R5 copy rop %0d", r));
    end
    // R4/R8: size sweep
    for (int w = 1; w <= 4; w++)
      for (int h = 1; h <= 3; h++)
        run_op(1'b0, 0, 64, 0, 64, 0, 0, w * 5, h * 4, w, h, 16'h0F0F + w * h,
               4'h6, 1'b0, 1'b0, $sformatf("R4 size %0dx%0d", w, h));
    // R3: copy between surfaces with different pitch and base
    run_op(1'b1, 0, 64, 2048, 40, 5, 6, 1, 2, 8, 5, 0, 4'hC, 1'b0, 1'b0, "R3 cross surface");
    // R7: overlapping copies, four directions
    run_op(1'b1, 0, 64, 0, 64, 4, 4, 6, 7, 10, 8, 0, 4'hC, 1'b0, 1'b0, "R7 dst below");
    run_op(1'b1, 0, 64, 0, 64, 6, 8, 4, 5, 10, 8, 0, 4'hC, 1'b0, 1'b0, "R7 dst above");
    run_op(1'b1, 0, 64, 0, 64, 2, 10, 5, 10, 12, 3, 0, 4'hC, 1'b0, 1'b0, "R7 dst right");
    run_op(1'b1, 0, 64, 0, 64, 9, 12, 3, 12, 12, 3, 0, 4'hC, 1'b0, 1'b0, "R7 dst left");
    run_op(1'b1, 0, 64, 0, 64, 3, 3, 5, 4, 9, 9, 0, 4'h6, 1'b0, 1'b0, "R7 diag xor");
    run_op(1'b1, 0, 64, 0, 64, 8, 9, 6, 6, 9, 9, 0, 4'hE, 1'b0, 1'b0, "R7 diag up-left");
    // R10: empty rectangles
    run_op(1'b0, 0, 64, 0, 64, 0, 0, 2, 2, 0, 5, 16'hFFFF, 4'hC, 1'b0, 1'b0, "R10 zero width");
    run_op(1'b1, 0, 64, 0, 64, 1, 1, 2, 2, 5, 0, 0, 4'hC, 1'b0, 1'b0, "R10 zero height");
    // R9: writes during a job are dropped; next fill keeps old colour
    run_op(1'b0, 0, 64, 0, 64, 0, 0, 10, 25, 6, 3, 16'h4C1D, 4'hC, 1'b0, 1'b1, "R9 inject");
    run_op(1'b0, 0, 64, 0, 64, 0, 0, 17, 26, 5, 2, 0, 4'hC, 1'b1, 1'b0, "R9 colour kept");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule